// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block decides when an embedded program or erase operation inside a parallel NOR flash has finished. After a start pulse it repeatedly reads one status address on the flash bus and compares the toggle bit (bit 6) of two reads in a row. While the device is still busy, that bit changes on every read. Once the bit stays the same across a pair of reads, the operation is over. Bit 5 is the device's error flag. It only counts when a second pair of reads in the same iteration still toggles.

The poller talks to a simple read port with a fixed latency. It raises `rdReq` for one cycle with the held address, and `rdData` is sampled exactly `READ_LATENCY` cycles later. Only one read is ever in flight. A tick budget is checked at the top of every iteration: zero times out at once and the all-ones value disables the limit. The final code is held on `result`, and `done` pulses for one clock in the cycle that code first appears.

Top module: `nor_toggle_poller`

## Requirements
- R1: While reset is applied and after it, `result` reads 0 (ongoing), `done` is low and `rdReq` is low.
- R2: A start pulse accepted while idle latches `pollAddr` and `timeoutTicks` and sets `result` to 0 on the next clock. Every read request then carries the latched address. Each request lasts one cycle, and the next request comes only after the data for the previous one has been sampled, `READ_LATENCY` cycles after its request.
- R3: Reads are taken in pairs. When bit 6 is equal in the two reads of a pair, whichever pair it is, polling stops with `result` = 1 (success) and no further read is issued.
- R4: When the first pair of an iteration toggles, a second pair is read at once. Bit 5 of the first pair has no effect.
- R5: When the second pair also toggles and bit 5 of its first read is 1, polling stops with `result` = 2 (error). Bit 5 of its second read is not looked at.
- R6: When the second pair toggles with bit 5 of its first read at 0, a new iteration begins with its timeout check.
- R7: The timeout check runs at the top of each iteration. It counts clock ticks since the accepted start, and when that count is at or above the latched limit the block stops with `result` = 3 (timeout). With a limit of 0 it ends with no read at all, and `done` is seen two clocks after the start clock.
- R8: A limit of all ones (0xFFFF at the default width) never times out.
- R9: If the limit runs out during an iteration, that iteration still completes. A success or error found in it is reported instead of timeout.
- R10: `done` is high for exactly one clock, in the first cycle the final code shows on `result`. The code then holds until the next accepted start.
- R11: A start pulse that arrives while polling is in progress is ignored. It changes neither the address, the limit nor the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| pollAddr | input | ADDR_W | Status address to read |
| timeoutTicks | input | TICK_W | Tick budget; 0 means immediate timeout, all ones means no limit |
| rdReq | output | 1 | One-cycle read request to the flash bus |
| rdAddr | output | ADDR_W | Address of the read request |
| rdData | input | DATA_W | Read data, valid READ_LATENCY cycles after the request |
| result | output | 2 | 0 ongoing, 1 success, 2 error, 3 timeout |
| done | output | 1 | One-cycle pulse when a final code is loaded |

## Verification
The checks inside the design take for granted that the read port really is fixed-latency. Each request's data must show on `rdData` exactly `READ_LATENCY` clocks later. With anything else, the pair compare would see stale words, and the error and success checks would relate the wrong bits. The bench flash model keeps to this contract with a shift register of the same depth. It drives a filler word on every cycle that holds no returned data, so a capture taken on the wrong cycle shows up as a wrong outcome. Stimulus changes only on falling edges, and starts are one clock long, as the checks on start handling expect.

// File: rtl/toggle_poll_pkg.sv
`timescale 1ns/1ps
package toggle_poll_pkg;

  typedef enum logic [1:0] {
    RES_ONGOING = 2'd0,
    RES_SUCCESS = 2'd1,
    RES_ERROR   = 2'd2,
    RES_TIMEOUT = 2'd3
  } pollResult_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic        running;     // a poll is in progress
    logic        armRun;      // accept start: latch inputs, clear result
    logic        issueRead;   // drive one read request
    logic        capFirst;    // sample returning word as first of pair
    logic        capSecond;   // sample returning word as second of pair
    logic        loadResult;  // load final code and pulse done
    pollResult_e resultCode;
  } pollStrobe_t;

endpackage

// File: rtl/toggle_poll_control.sv
`timescale 1ns/1ps
module toggle_poll_control
  import toggle_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        dataDue,
  input  logic        toggled,
  input  logic        errFlag,
  input  logic        expired,
  output pollStrobe_t strobe,
  output logic        busy
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOP,
    ST_REQ,
    ST_WAIT,
    ST_EVAL
  } ctlState_e;

  ctlState_e state;
  ctlState_e nextState;
  logic      pairSel;   // 0: first pair of iteration, 1: second pair
  logic      readSel;   // 0: first read of pair, 1: second read

  always_comb begin
    strobe            = '0;
    strobe.resultCode = RES_ONGOING;
    strobe.running    = (state != ST_IDLE);
    nextState         = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.armRun = 1'b1;
          nextState     = ST_TOP;
        end
      end
      ST_TOP: begin
        if (expired) begin
          strobe.loadResult = 1'b1;
          strobe.resultCode = RES_TIMEOUT;
          nextState         = ST_IDLE;
        end else begin
          nextState = ST_REQ;
        end
      end
      ST_REQ: begin
        strobe.issueRead = 1'b1;
        nextState        = ST_WAIT;
      end
      ST_WAIT: begin
        if (dataDue) begin
          strobe.capFirst  = ~readSel;
          strobe.capSecond = readSel;
          nextState        = readSel ? ST_EVAL : ST_REQ;
        end
      end
      ST_EVAL: begin
        if (!toggled) begin
          strobe.loadResult = 1'b1;
          strobe.resultCode = RES_SUCCESS;
          nextState         = ST_IDLE;
        end else if (!pairSel) begin
          nextState = ST_REQ;
        end else if (errFlag) begin
          strobe.loadResult = 1'b1;
          strobe.resultCode = RES_ERROR;
          nextState         = ST_IDLE;
        end else begin
          nextState = ST_TOP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pairSel <= 1'b0;
      readSel <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_TOP) begin
        readSel <= 1'b0;
        pairSel <= 1'b0;
      end else begin
        if (state == ST_WAIT && dataDue)
          readSel <= ~readSel;
        if (state == ST_EVAL && toggled && !pairSel)
          pairSel <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  AST_MATCH_ENDS_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && !toggled) |=> (state == ST_IDLE)); // R3

  AST_FIRST_PAIR_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && !pairSel && toggled) |=> (state == ST_REQ)); // R4

  AST_SECOND_PAIR_LOOPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && pairSel && toggled && !errFlag) |=> (state == ST_TOP)); // R6

endmodule

// File: rtl/toggle_poll_datapath.sv
`timescale 1ns/1ps
module toggle_poll_datapath
  import toggle_poll_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int TICK_W       = 16,
  parameter int READ_LATENCY = 2,
  parameter int TOGGLE_BIT   = 6,
  parameter int ERROR_BIT    = 5
)(
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strobe,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [TICK_W-1:0] timeoutTicks,
  input  logic [DATA_W-1:0] rdData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              dataDue,
  output logic              toggled,
  output logic              errFlag,
  output logic              expired,
  output logic [1:0]        result,
  output logic              done
);

  localparam logic [TICK_W-1:0] NO_LIMIT = {TICK_W{1'b1}};

  logic [ADDR_W-1:0]       addrReg;
  logic [TICK_W-1:0]       limitReg;
  logic [TICK_W-1:0]       elapsed;
  logic [DATA_W-1:0]       firstRd;
  logic [DATA_W-1:0]       secondRd;
  logic [READ_LATENCY-1:0] duePipe;
  pollResult_e             resultReg;
  logic                    doneReg;

  // Held address and tick limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      limitReg <= '0;
    end else if (strobe.armRun) begin
      addrReg  <= pollAddr;
      limitReg <= timeoutTicks;
    end
  end

  // Saturating tick counter from the accepted start
  always_ff @(posedge clk) begin
    if (!rstN)
      elapsed <= '0;
    else if (strobe.armRun)
      elapsed <= '0;
    else if (strobe.running && elapsed != NO_LIMIT)
      elapsed <= elapsed + 1'b1;
  end

  assign expired = (limitReg != NO_LIMIT) && (elapsed >= limitReg);

  // Return timing of the fixed-latency read port
  generate
    if (READ_LATENCY == 1) begin : gSingleStage
      always_ff @(posedge clk) begin
        if (!rstN) duePipe <= '0;
        else       duePipe <= strobe.issueRead;
      end
    end else begin : gShiftStages
      always_ff @(posedge clk) begin
        if (!rstN) duePipe <= '0;
        else       duePipe <= {duePipe[READ_LATENCY-2:0], strobe.issueRead};
      end
    end
  endgenerate

  assign dataDue = duePipe[READ_LATENCY-1];

  // Pair capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstRd  <= '0;
      secondRd <= '0;
    end else begin
      if (strobe.capFirst)  firstRd  <= rdData;
      if (strobe.capSecond) secondRd <= rdData;
    end
  end

  assign toggled = firstRd[TOGGLE_BIT] ^ secondRd[TOGGLE_BIT];
  assign errFlag = firstRd[ERROR_BIT];

  // Result and completion pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= RES_ONGOING;
      doneReg   <= 1'b0;
    end else if (strobe.armRun) begin
      resultReg <= RES_ONGOING;
      doneReg   <= 1'b0;
    end else if (strobe.loadResult) begin
      resultReg <= strobe.resultCode;
      doneReg   <= 1'b1;
    end else begin
      doneReg   <= 1'b0;
    end
  end

  assign rdReq  = strobe.issueRead;
  assign rdAddr = addrReg;
  assign result = resultReg;
  assign done   = doneReg;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armRun |=> (result == RES_ONGOING && elapsed == '0)); // R2

  AST_SUCCESS_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadResult && strobe.resultCode == RES_SUCCESS) |-> !toggled); // R3

  AST_ERROR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadResult && strobe.resultCode == RES_ERROR) |-> (toggled && errFlag)); // R5

  AST_TIMEOUT_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadResult && strobe.resultCode == RES_TIMEOUT) |-> expired); // R7

  AST_NO_LIMIT_NEVER_EXPIRES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.running && limitReg == NO_LIMIT) |-> !expired); // R8

endmodule

// File: rtl/nor_toggle_poller.sv
`timescale 1ns/1ps
module nor_toggle_poller
  import toggle_poll_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int TICK_W       = 16,
  parameter int READ_LATENCY = 2,
  parameter int TOGGLE_BIT   = 6,
  parameter int ERROR_BIT    = 5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [TICK_W-1:0] timeoutTicks,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [1:0]        result,
  output logic              done
);

  pollStrobe_t ctlStrobe;
  logic        dataDue;
  logic        toggled;
  logic        errFlag;
  logic        expired;
  logic        busy;

  toggle_poll_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .dataDue (dataDue),
    .toggled (toggled),
    .errFlag (errFlag),
    .expired (expired),
    .strobe  (ctlStrobe),
    .busy    (busy)
  );

  toggle_poll_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .TICK_W       (TICK_W),
    .READ_LATENCY (READ_LATENCY),
    .TOGGLE_BIT   (TOGGLE_BIT),
    .ERROR_BIT    (ERROR_BIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (ctlStrobe),
    .pollAddr     (pollAddr),
    .timeoutTicks (timeoutTicks),
    .rdData       (rdData),
    .rdReq        (rdReq),
    .rdAddr       (rdAddr),
    .dataDue      (dataDue),
    .toggled      (toggled),
    .errFlag      (errFlag),
    .expired      (expired),
    .result       (result),
    .done         (done)
  );

  AST_ONE_READ_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R2

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> $stable(rdAddr)); // R11

  AST_DONE_ONLY_WITH_CODE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result != RES_ONGOING)); // R10

endmodule

// File: tb/tb_nor_toggle_poller.sv
`timescale 1ns/100ps
module tb_nor_toggle_poller;

  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int TW  = 16;
  localparam int LAT = 2;
  localparam int NV  = 14;

  // {words[97:34], limit[33:18], result[17:16], reads[15:8], latency[7:0]}
  localparam logic [97:0] VEC [NV] = '{
    {64'h0000_0000_0000_0000, 16'hFFFF, 2'd1, 8'd2,  8'd9 },
    {64'h4040_0000_0000_0000, 16'hFFFF, 2'd1, 8'd2,  8'd9 },
    {64'h0040_4040_0000_0000, 16'hFFFF, 2'd1, 8'd4,  8'd16},
    {64'h0040_2060_0000_0000, 16'hFFFF, 2'd2, 8'd4,  8'd16},
    {64'h0040_0040_4040_0000, 16'hFFFF, 2'd1, 8'd6,  8'd24},
    {64'h2060_0000_0000_0000, 16'hFFFF, 2'd1, 8'd4,  8'd16},
    {64'h0040_4000_6020_2060, 16'hFFFF, 2'd2, 8'd8,  8'd31},
    {64'h0040_0060_0000_0000, 16'hFFFF, 2'd1, 8'd6,  8'd24},
    {64'h0040_0040_0000_0000, 16'd5,    2'd3, 8'd4,  8'd17},
    {64'h0040_0000_0000_0000, 16'd5,    2'd1, 8'd4,  8'd16},
    {64'h0040_2060_0000_0000, 16'd5,    2'd2, 8'd4,  8'd16},
    {64'h0040_0040_0040_0040, 16'd30,   2'd3, 8'd8,  8'd32},
    {64'h0040_0040_0040_0040, 16'd31,   2'd3, 8'd12, 8'd47},
    {64'h0000_0000_0000_0000, 16'd0,    2'd3, 8'd0,  8'd2 }
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [AW-1:0] pollAddr;
  logic [TW-1:0] timeoutTicks;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic [1:0]    result;
  logic          done;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  nor_toggle_poller #(
    .ADDR_W(AW), .DATA_W(DW), .TICK_W(TW), .READ_LATENCY(LAT)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .pollAddr(pollAddr),
    .timeoutTicks(timeoutTicks), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .result(result), .done(done)
  );

  // Flash status model: scripted words, then endless toggling without error
  logic [63:0]   modelWords;
  logic [AW-1:0] expAddr;
  logic          modelClr;
  int            modelCount;
  int            addrBad;
  logic [DW-1:0] mPipe [LAT];

  function automatic logic [7:0] modelWord(input int k);
    if (k < 8) return modelWords[63 - 8*k -: 8];
    return (k % 2 == 1) ? 8'h40 : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (modelClr) begin
      modelCount <= 0;
      addrBad    <= 0;
    end else if (rdReq) begin
      modelCount <= modelCount + 1;
      if (rdAddr != expAddr) addrBad <= addrBad + 1;
    end
    mPipe[0] <= rdReq ? {8'h00, modelWord(modelCount)} : 16'hDEAD;
    for (int i = 1; i < LAT; i++) mPipe[i] <= mPipe[i-1];
  end

  assign rdData = mPipe[LAT-1];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int code);
    case (code)
      1:       return "R3";
      2:       return "R5";
      default: return "R7";
    endcase
  endfunction

  // One poll: start at a falling edge, count falling edges until done
  task automatic runPoll(input logic [63:0] words, input logic [TW-1:0] lim,
                         input logic [AW-1:0] addr, input int expRes,
                         input int expReads, input int expLat,
                         input int ignoreAt, input string tag);
    int lat;
    @(negedge clk);
    modelWords   = words;
    expAddr      = addr;
    pollAddr     = addr;
    timeoutTicks = lim;
    start        = 1'b1;
    modelClr     = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    modelClr = 1'b0;
    check(result == 2'd0, "R2", "result cleared after start", result, 0);
    lat = 1;
    while (!done && lat < 400) begin
      if (lat == ignoreAt) begin
        pollAddr     = ~addr;
        timeoutTicks = '0;
        start        = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(done == 1'b1, tag, "done seen", done, 1);
    check(int'(result) == expRes, tag, "result code", result, expRes);
    check(modelCount == expReads, tag, "read count", modelCount, expReads);
    check(lat == expLat, tag, "done latency", lat, expLat);
    check(addrBad == 0, "R2", "reads at latched address", addrBad, 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done lasts one clock", done, 0);
    check(int'(result) == expRes, "R10", "result held", result, expRes);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN         = 1'b0;
    start        = 1'b0;
    modelClr     = 1'b1;
    modelWords   = '0;
    expAddr      = '0;
    pollAddr     = '0;
    timeoutTicks = '0;
    repeat (3) @(negedge clk);
    check(result == 2'd0, "R1", "result in reset", result, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(rdReq == 1'b0, "R1", "rdReq in reset", rdReq, 0);
    rstN     = 1'b1;
    modelClr = 1'b0;
    @(negedge clk);
    check(result == 2'd0 && done == 1'b0 && rdReq == 1'b0, "R1",
          "idle after reset", {result, done, rdReq}, 0);

    // Table of outcome vectors
    for (int v = 0; v < NV; v++) begin
      runPoll(VEC[v][97:34], VEC[v][33:18], 24'h1000 + 24'(v * 24'h111),
              int'(VEC[v][17:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), 0,
              (v >= 8 && v <= 10) ? "R9" : tagOf(int'(VEC[v][17:16])));
    end

    // R11: start during polling with another address and a zero limit
    runPoll(64'h0040_4000_6020_2060, 16'hFFFF, 24'hABCDE0, 2, 8, 31, 5, "R11");

    // R6 and R8: endless toggling with no limit, then reset mid-poll
    @(negedge clk);
    modelWords   = 64'h0040_0040_0040_0040;
    expAddr      = 24'h0F0F0F;
    pollAddr     = 24'h0F0F0F;
    timeoutTicks = 16'hFFFF;
    start        = 1'b1;
    modelClr     = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    modelClr = 1'b0;
    begin
      int doneSeen = 0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if (done) doneSeen++;
      end
      check(doneSeen == 0, "R8", "no completion without limit", doneSeen, 0);
      check(result == 2'd0, "R8", "still ongoing", result, 0);
      check(modelCount >= 36, "R6", "iterations continue", modelCount, 36);
    end
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(result == 2'd0 && rdReq == 1'b0, "R1", "reset aborts poll",
          {result, rdReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runPoll(64'h4040_0000_0000_0000, 16'd0, 24'h000042, 3, 0, 2, 0, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule